// File: doc/BRIEF.md
# Light Pen Position Latch

This block records where the display beam was when a light pen saw it. It watches an asynchronous pen input. On each low-to-high transition of that input it stores the running 14-bit display scan address into a read-only holding register. It also raises a flag saying that a fresh position is waiting.

The processor side uses three single-cycle read strobes: one for the upper part of the stored position, one for the lower byte, and one for a status byte. The status byte carries the waiting-position flag and the current vertical blanking indication. Reading either half of the position retires the flag.

Everything runs on the character clock. The scan address advances once per cycle, and the pen input is resynchronised before use. The stored address is deliberately two characters ahead of the one on the bus when the strobe arrived. The synchronizer length is a parameter, and a compensating delay line on the address keeps that two-character lead fixed whatever the synchronizer depth.

Top module: `lpen_latch`

## Requirements
- R1: A synchronous active-high reset clears the stored position to zero, clears the waiting flag, and sets the read data output to zero.
- R2: Only a low-to-high transition of the pen input starts a capture. A pen input held high, or a high-to-low transition, leaves the stored position and the waiting flag unchanged.
- R3: Let edge k be the first rising clock edge at which the pen input is high, and let n be the scan address present at edge k. The stored position is then n+2, modulo 2^14 (0x3FFE gives 0x0000).
- R4: A read strobe sampled at a clock edge sets the read data output at that same edge, and the output holds until the next strobe. The high-half read returns position bits 13:8 in data bits 5:0, with bits 7:6 zero. The low-half read returns position bits 7:0.
- R5: The status read returns the waiting flag in bit 6 and the vertical blanking input (sampled with the strobe) in bit 5. All other bits are zero.
- R6: A capture sets the waiting flag. A high-half or low-half read clears it. When a capture and a half read fall on the same edge, the flag ends up set and the read returns the previous position.
- R7: A new pen strobe that arrives while the waiting flag is set overwrites the stored position.
- R8: A pen pulse that is high for only one clock cycle is captured.
- R9: When several read strobes are active together, the high half wins over the low half, and the low half wins over the status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| scan_addr | input | 14 | Running display scan address, one step per character |
| vblank | input | 1 | Vertical blanking indication, reported in status |
| pen_in | input | 1 | Asynchronous light pen strobe, rising edge active |
| rd_hi | input | 1 | Read strobe for the upper position bits |
| rd_lo | input | 1 | Read strobe for the lower position byte |
| rd_stat | input | 1 | Read strobe for the status byte |
| rd_data | output | 8 | Registered read data |

## Verification
The hardest case to reach is a capture and a half read landing on the very same clock edge. The pen's effect appears only after the synchronizer delay, so the bench raises the pen and then counts exactly two falling edges before asserting the low-half strobe. This makes both events meet at the capture edge, where the flag must survive and the read must return the old position. The two-character lead is checked with a scan address that the bench steps once per cycle from a chosen start. This includes a start just below the top of the 14-bit range, so the lead wraps to zero.

// File: rtl/lpen_pkg.sv
package lpen_pkg;

  localparam int unsigned STAT_FULL_BIT = 6;
  localparam int unsigned STAT_VBL_BIT  = 5;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_HI   = 2'd1,
    SEL_LO   = 2'd2,
    SEL_STAT = 2'd3
  } rd_sel_e;

endpackage

// File: rtl/lpen_sync.sv
module lpen_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic rise
);

  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-1:0], pin};
  end

  assign rise = chain[STAGES-1] & ~chain[STAGES];

  // A single transition yields exactly one pulse (R2)
  p_single_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);

endmodule

// File: rtl/lpen_align.sv
module lpen_align #(
  parameter int unsigned WIDTH = 14,
  parameter int unsigned LAG   = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] addr_in,
  output logic [WIDTH-1:0] addr_out
);

  generate
    if (LAG == 0) begin : g_direct
      assign addr_out = addr_in;
    end else begin : g_delay
      logic [WIDTH-1:0] dly [LAG];
      always_ff @(posedge clk) begin
        if (rst) dly[0] <= '0;
        else     dly[0] <= addr_in;
      end
      for (genvar i = 1; i < LAG; i++) begin : g_tap
        always_ff @(posedge clk) begin
          if (rst) dly[i] <= '0;
          else     dly[i] <= dly[i-1];
        end
      end
      assign addr_out = dly[LAG-1];
    end
  endgenerate

endmodule

// File: rtl/lpen_capture.sv
module lpen_capture #(
  parameter int unsigned WIDTH = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap,
  input  logic             clr,
  input  logic [WIDTH-1:0] addr_in,
  output logic [WIDTH-1:0] value,
  output logic             full
);

  always_ff @(posedge clk) begin
    if (rst) begin
      value <= '0;
      full  <= 1'b0;
    end else begin
      if (cap) value <= addr_in;
      if (cap)      full <= 1'b1;
      else if (clr) full <= 1'b0;
    end
  end

  p_full_set_r6: assert property (@(posedge clk) disable iff (rst)
    cap |=> full);

  p_full_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (clr && !cap) |=> !full);

  p_value_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !cap |=> $stable(value));

endmodule

// File: rtl/lpen_readout.sv
module lpen_readout
  import lpen_pkg::*;
#(
  parameter int unsigned ADDR_W = 14,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_hi,
  input  logic              rd_lo,
  input  logic              rd_stat,
  input  logic [ADDR_W-1:0] value,
  input  logic              full,
  input  logic              vblank,
  output logic [DATA_W-1:0] rd_data
);

  localparam int unsigned HI_W = ADDR_W - DATA_W;
  localparam logic [DATA_W-1:0] STAT_MASK =
    DATA_W'((1 << STAT_FULL_BIT) | (1 << STAT_VBL_BIT));

  rd_sel_e          sel;
  logic [DATA_W-1:0] hi_word, lo_word, st_word;

  always_comb begin
    if (rd_hi)        sel = SEL_HI;
    else if (rd_lo)   sel = SEL_LO;
    else if (rd_stat) sel = SEL_STAT;
    else              sel = SEL_NONE;
  end

  always_comb begin
    hi_word = '0;
    hi_word[HI_W-1:0] = value[ADDR_W-1:DATA_W];
    lo_word = value[DATA_W-1:0];
    st_word = '0;
    st_word[STAT_FULL_BIT] = full;
    st_word[STAT_VBL_BIT]  = vblank;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      case (sel)
        SEL_HI:   rd_data <= hi_word;
        SEL_LO:   rd_data <= lo_word;
        SEL_STAT: rd_data <= st_word;
        default:  rd_data <= rd_data;
      endcase
    end
  end

  p_hi_pad_r4: assert property (@(posedge clk) disable iff (rst)
    rd_hi |=> (rd_data[DATA_W-1:HI_W] == '0));

  p_stat_pad_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_stat && !rd_hi && !rd_lo) |=> ((rd_data & ~STAT_MASK) == '0));

  p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!rd_hi && !rd_lo && !rd_stat) |=> $stable(rd_data));

endmodule

// File: rtl/lpen_latch.sv
module lpen_latch #(
  parameter int unsigned ADDR_W      = 14,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned LEAD        = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] scan_addr,
  input  logic              vblank,
  input  logic              pen_in,
  input  logic              rd_hi,
  input  logic              rd_lo,
  input  logic              rd_stat,
  output logic [DATA_W-1:0] rd_data
);

  localparam int unsigned LAG = SYNC_STAGES - LEAD;

  logic              pen_rise;
  logic [ADDR_W-1:0] aligned_addr;
  logic [ADDR_W-1:0] pos_value;
  logic              pos_full;
  logic              half_read;

  assign half_read = rd_hi | rd_lo;

  lpen_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .pin  (pen_in),
    .rise (pen_rise)
  );

  lpen_align #(.WIDTH(ADDR_W), .LAG(LAG)) u_align (
    .clk      (clk),
    .rst      (rst),
    .addr_in  (scan_addr),
    .addr_out (aligned_addr)
  );

  lpen_capture #(.WIDTH(ADDR_W)) u_cap (
    .clk     (clk),
    .rst     (rst),
    .cap     (pen_rise),
    .clr     (half_read),
    .addr_in (aligned_addr),
    .value   (pos_value),
    .full    (pos_full)
  );

  lpen_readout #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .rd_hi   (rd_hi),
    .rd_lo   (rd_lo),
    .rd_stat (rd_stat),
    .value   (pos_value),
    .full    (pos_full),
    .vblank  (vblank),
    .rd_data (rd_data)
  );

endmodule

// File: tb/lpen_latch_test.sv
module lpen_latch_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [13:0] scan_addr = '0;
  logic        vblank = 1'b0;
  logic        pen_in = 1'b0;
  logic        rd_hi = 1'b0, rd_lo = 1'b0, rd_stat = 1'b0;
  logic [7:0]  rd_data;

  int n_checks = 0;
  int n_fail   = 0;

  lpen_latch uut (
    .clk(clk), .rst(rst), .scan_addr(scan_addr), .vblank(vblank),
    .pen_in(pen_in), .rd_hi(rd_hi), .rd_lo(rd_lo), .rd_stat(rd_stat),
    .rd_data(rd_data)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    scan_addr <= scan_addr + 14'd1;
  endtask

  // sel: 1 high, 2 low, 3 status
  task automatic do_read(input int sel, output logic [7:0] d);
    @(negedge clk);
    scan_addr <= scan_addr + 14'd1;
    rd_hi <= (sel == 1); rd_lo <= (sel == 2); rd_stat <= (sel == 3);
    @(negedge clk);
    scan_addr <= scan_addr + 14'd1;
    rd_hi <= 1'b0; rd_lo <= 1'b0; rd_stat <= 1'b0;
    d = rd_data;
  endtask

  task automatic strobe(input logic [13:0] start, input int hold);
    @(negedge clk);
    scan_addr <= start;
    pen_in <= 1'b1;
    repeat (hold) tick();
    pen_in <= 1'b0;
    repeat (6) tick();
  endtask

  task automatic read_pos(output logic [13:0] p);
    logic [7:0] h, l;
    do_read(1, h);
    do_read(2, l);
    p = {h[5:0], l};
    check("R4 hi pad", {8'h0, h[7:6]}, 16'h0);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst <= 1'b0;
    @(negedge clk);
    check("R1 rd_data after reset", {8'h0, rd_data}, 16'h0);
    do_read(3, d); check("R1 status after reset", {8'h0, d}, 16'h0);
    do_read(2, d); check("R1 low after reset", {8'h0, d}, 16'h0);
  endtask

  task automatic t_basic();
    logic [13:0] p; logic [7:0] d;
    strobe(14'h1234, 3);
    do_read(3, d); check("R6 full set", {8'h0, d}, 16'h40);
    read_pos(p);   check("R3 n+2 capture", {2'b0, p}, 16'h1236);
    do_read(3, d); check("R6 full cleared by read", {8'h0, d}, 16'h0);
    strobe(14'h2A0F, 2);
    do_read(2, d); check("R4 low half", {8'h0, d}, 16'h11);
    do_read(3, d); check("R6 low read clears", {8'h0, d}, 16'h0);
    do_read(1, d); check("R4 high half", {8'h0, d}, 16'h2A);
  endtask

  task automatic t_wrap();
    logic [13:0] p;
    strobe(14'h3FFE, 2);
    read_pos(p); check("R3 wrap", {2'b0, p}, 16'h0000);
  endtask

  task automatic t_short();
    logic [13:0] p;
    strobe(14'h0500, 1);
    read_pos(p); check("R8 one-cycle pulse", {2'b0, p}, 16'h0502);
  endtask

  task automatic t_level();
    logic [13:0] p; logic [7:0] d;
    @(negedge clk); scan_addr <= 14'h0100; pen_in <= 1'b1;
    repeat (6) tick();
    read_pos(p); check("R3 level start", {2'b0, p}, 16'h0102);
    repeat (10) tick();
    do_read(3, d); check("R2 held high no capture", {8'h0, d}, 16'h0);
    pen_in <= 1'b0;
    repeat (10) tick();
    do_read(3, d); check("R2 falling no capture", {8'h0, d}, 16'h0);
    read_pos(p); check("R2 value kept", {2'b0, p}, 16'h0102);
  endtask

  task automatic t_overwrite();
    logic [13:0] p;
    strobe(14'h0A00, 2);
    strobe(14'h0B10, 2);
    read_pos(p); check("R7 overwrite while full", {2'b0, p}, 16'h0B12);
  endtask

  task automatic t_collide();
    logic [7:0] d; logic [7:0] old_lo;
    strobe(14'h0020, 2);
    do_read(2, old_lo);
    @(negedge clk); scan_addr <= 14'h0300; pen_in <= 1'b1;  // edge k
    tick();                                               // edge k+1
    @(negedge clk); scan_addr <= scan_addr + 14'd1; rd_lo <= 1'b1; // edge k+2
    @(negedge clk); scan_addr <= scan_addr + 14'd1; rd_lo <= 1'b0;
    d = rd_data;
    check("R6 read at capture edge returns old", {8'h0, d}, {8'h0, old_lo});
    pen_in <= 1'b0;
    do_read(3, d); check("R6 capture beats clear", {8'h0, d}, 16'h40);
    do_read(2, d); check("R6 new value after collision", {8'h0, d}, 16'h02);
  endtask

  task automatic t_vblank();
    logic [7:0] d;
    vblank <= 1'b1;
    do_read(3, d); check("R5 vblank bit", {8'h0, d}, 16'h20);
    strobe(14'h0040, 2);
    do_read(3, d); check("R5 both flags", {8'h0, d}, 16'h60);
    vblank <= 1'b0;
    do_read(3, d); check("R5 vblank low", {8'h0, d}, 16'h40);
  endtask

  task automatic t_priority();
    logic [7:0] d;
    // position is 0x0042, full is set
    @(negedge clk); rd_hi <= 1'b1; rd_lo <= 1'b1; rd_stat <= 1'b1;
    @(negedge clk); rd_hi <= 1'b0; rd_lo <= 1'b0; rd_stat <= 1'b0;
    check("R9 high wins", {8'h0, rd_data}, 16'h00);
    strobe(14'h0140, 2);
    @(negedge clk); rd_lo <= 1'b1; rd_stat <= 1'b1;
    @(negedge clk); rd_lo <= 1'b0; rd_stat <= 1'b0;
    check("R9 low beats status", {8'h0, rd_data}, 16'h42);
    repeat (3) tick();
    check("R4 data holds", {8'h0, rd_data}, 16'h42);
  endtask

  task automatic t_reset_clears();
    logic [7:0] d;
    strobe(14'h0777, 2);
    @(negedge clk); rst <= 1'b1;
    repeat (2) @(negedge clk);
    rst <= 1'b0;
    do_read(3, d); check("R1 reset clears full", {8'h0, d}, 16'h0);
    do_read(2, d); check("R1 reset clears position", {8'h0, d}, 16'h0);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_wrap();
    t_short();
    t_level();
    t_overwrite();
    t_collide();
    t_vblank();
    t_priority();
    t_reset_clears();
    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(20 * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule